// File: doc/BRIEF.md
# Receive Trail Trace Message Capture

This block collects the trail-trace identifier that a remote terminal spreads across a run of consecutive E3 frames, one byte per frame. An upstream framer presents each frame's trail-trace byte together with a one-cycle frame strobe. A byte whose most significant bit is 1 is a start marker. It carries a 7-bit CRC in its low bits, and the block stores it into entry 0 of a 16-entry buffer. The bytes of the frames that follow fill entries 1 to 15 in order. The CRC is kept as received and is not checked.

Each start marker sets a sticky change flag and, when enabled, drives an interrupt. A processor reads the buffer entries and the status word through a simple registered read port. Reading the status word clears the flag.

The write side is a three-state machine. `ST_IDLE` waits for the first marker after reset. `ST_FILL` stores the bytes that follow a marker. `ST_FULL` ignores bytes once entry 15 has been written. The transitions are:
- any state to `ST_FILL` on a strobed marker (resync to entry 0);
- `ST_FILL` to `ST_FULL` when entry 15 is written;
- `ST_IDLE` and `ST_FULL` hold on strobed bytes whose MSB is 0.

Top module: `trace_rx_capture`

## Requirements
- R1: After reset, every buffer entry reads 0x00, the status word reads 0x00 and `irq` is low.
- R2: A strobed byte with bit 7 = 1 is written unchanged, all 8 bits including the CRC in bits 6:0, into entry 0 (address 0).
- R3: After a marker, the strobed bytes of the following frames are written into entries 1, 2, … 15 in that order; entry k is at read address k.
- R4: Once entry 15 has been written, strobed bytes with bit 7 = 0 change no entry until the next marker.
- R5: Before the first marker after reset, strobed bytes with bit 7 = 0 are discarded.
- R6: A strobed marker restarts filling at entry 0 from any position and sets the change flag every time.
- R7: The status word is at read address 16. Bit 6 is the change flag and all other bits read 0. Read data appears on `rd_data` the cycle after `rd_en`. A status read clears the flag. Addresses 17 to 31 read 0x00.
- R8: If a status read and a marker fall in the same cycle, the read returns the old flag value and the flag is set afterwards.
- R9: `irq` is high exactly when the change flag is set and `irq_en` is high. The flag is set regardless of `irq_en`.
- R10: When `frame_strobe` is low, `trace_byte` has no effect on entries or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_strobe | input | 1 | One cycle per received frame; qualifies `trace_byte` |
| trace_byte | input | 8 | Trail-trace byte of the current frame |
| irq_en | input | 1 | Interrupt enable |
| rd_en | input | 1 | Read request |
| rd_addr | input | 5 | Read address: 0–15 entries, 16 status |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Change interrupt (level) |

## Verification
The hardest situation to reach is a status read that coincides with a new marker. The stimulus drives the strobe, the marker byte and a status read in one cycle. It then reads the status again to show that the flag survived. Resynchronisation in mid-message, and overrun after entry 15, are reached by sending full 16-frame messages interleaved with early markers. A behavioural model with integer arrays predicts every read and the `irq` level on each clock.

// File: rtl/trace_pkg.sv
package trace_pkg;
    localparam int TRACE_ENTRIES = 16;
    localparam int TRACE_BYTE_W  = 8;
    localparam int STAT_FLAG_BIT = 6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_FULL = 2'd2
    } cap_state_t;
endpackage

// File: rtl/trace_wptr_fsm.sv
module trace_wptr_fsm
    import trace_pkg::*;
#(
    parameter int N_ENTRIES = TRACE_ENTRIES,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_strobe,
    input  logic             marker,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             change_evt
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENTRIES - 1);

    cap_state_t       state_q, state_d;
    logic [IDX_W-1:0] ptr_q, ptr_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        ptr_d      = ptr_q;
        wr_en      = 1'b0;
        wr_idx     = ptr_q;
        change_evt = 1'b0;
        if (frame_strobe) begin
            if (marker) begin
                wr_en      = 1'b1;
                wr_idx     = '0;
                change_evt = 1'b1;
                state_d    = ST_FILL;
                ptr_d      = IDX_W'(1);
            end else begin
                unique case (state_q)
                    ST_IDLE: state_d = ST_IDLE;
                    ST_FILL: begin
                        wr_en  = 1'b1;
                        wr_idx = ptr_q;
                        if (ptr_q == LAST_IDX) state_d = ST_FULL;
                        else                   ptr_d   = ptr_q + IDX_W'(1);
                    end
                    ST_FULL: state_d = ST_FULL;
                    default: state_d = ST_IDLE;
                endcase
            end
        end
    end

    assert_resync_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && marker) |=> (state_q == ST_FILL && ptr_q == IDX_W'(1)));
    assert_discard_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !marker) |-> !wr_en);
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL && !marker) |-> !wr_en);
    assert_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !marker && wr_idx != LAST_IDX) |=> (ptr_q == $past(wr_idx) + IDX_W'(1)));
endmodule

// File: rtl/trace_store.sv
module trace_store #(
    parameter int N_ENTRIES = 16,
    parameter int BYTE_W    = 8,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BYTE_W-1:0] rd_word
);
    logic [BYTE_W-1:0] entry_q [N_ENTRIES];

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)                                 entry_q[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))      entry_q[g] <= wr_data;
        end
    end

    assign rd_word = entry_q[rd_idx];

    assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (entry_q[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/trace_flag.sv
module trace_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_rd,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr_rd)  flag <= 1'b0;
    end

    assert_event_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);
    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rd && !set_evt) |=> !flag);
    assert_collision_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rd && set_evt) |=> flag);
endmodule

// File: rtl/trace_rx_capture.sv
module trace_rx_capture
    import trace_pkg::*;
#(
    parameter int N_ENTRIES = TRACE_ENTRIES,
    parameter int BYTE_W    = TRACE_BYTE_W,
    parameter int FLAG_BIT  = STAT_FLAG_BIT,
    localparam int IDX_W    = $clog2(N_ENTRIES),
    localparam int ADDR_W   = $clog2(N_ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_strobe,
    input  logic [BYTE_W-1:0] trace_byte,
    input  logic              irq_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(N_ENTRIES);

    logic             wr_en, change_evt, flag, stat_rd;
    logic [IDX_W-1:0] wr_idx;
    logic [BYTE_W-1:0] buf_word, stat_word, rd_mux;

    trace_wptr_fsm #(.N_ENTRIES(N_ENTRIES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe),
        .marker(trace_byte[BYTE_W-1]), .wr_en(wr_en), .wr_idx(wr_idx),
        .change_evt(change_evt)
    );

    trace_store #(.N_ENTRIES(N_ENTRIES), .BYTE_W(BYTE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(trace_byte), .rd_idx(rd_addr[IDX_W-1:0]), .rd_word(buf_word)
    );

    assign stat_rd = rd_en && (rd_addr == STAT_ADDR);

    trace_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set_evt(change_evt), .clr_rd(stat_rd), .flag(flag)
    );

    always_comb begin
        stat_word           = '0;
        stat_word[FLAG_BIT] = flag;
        if (rd_addr < STAT_ADDR)       rd_mux = buf_word;
        else if (rd_addr == STAT_ADDR) rd_mux = stat_word;
        else                           rd_mux = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    assign irq = flag && irq_en;

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
    assert_entry0_marker_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == '0) |-> trace_byte[BYTE_W-1]);
    assert_strobe_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_strobe |-> (!wr_en && !change_evt));
    assert_stat_unused_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == STAT_ADDR) |=> ((rd_data & ~(BYTE_W'(1) << FLAG_BIT)) == '0));
endmodule

// File: tb/trace_rx_capture_tb_top.sv
`timescale 1ns/100ps
module trace_rx_capture_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_strobe = 1'b0;
    logic [7:0] trace_byte = 8'h00;
    logic       irq_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [4:0] rd_addr = 5'd0;
    logic [7:0] rd_data;
    logic       irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    int mem [16];
    int mptr = 0;
    int mstate = 0;   // 0 waiting, 1 filling, 2 full
    bit mflag = 1'b0;

    always #2.5 clk = ~clk;

    trace_rx_capture dut_i (
        .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe), .trace_byte(trace_byte),
        .irq_en(irq_en), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input bit stb, input logic [7:0] b, input bit rd,
                        input int addr, input string tag);
        int exp_rd;
        @(negedge clk);
        frame_strobe = stb; trace_byte = b; rd_en = rd; rd_addr = 5'(addr);
        @(posedge clk);
        if (addr < 16)       exp_rd = mem[addr];
        else if (addr == 16) exp_rd = mflag ? 8'h40 : 8'h00;
        else                 exp_rd = 0;
        if (stb && b[7]) begin
            mem[0] = b; mptr = 1; mstate = 1;
        end else if (stb && mstate == 1) begin
            mem[mptr] = b;
            if (mptr == 15) mstate = 2; else mptr++;
        end
        if (stb && b[7])              mflag = 1'b1;
        else if (rd && addr == 16)    mflag = 1'b0;
        #1;
        if (rd) check(tag, rd_data, exp_rd);
        check("R9 irq", irq, (mflag && irq_en) ? 1 : 0);
        frame_strobe = 1'b0; rd_en = 1'b0;
    endtask

    task automatic rd(input int addr, input string tag);
        step(1'b0, 8'h00, 1'b1, addr, tag);
    endtask

    task automatic frame(input logic [7:0] b, input string tag);
        step(1'b1, b, 1'b0, 0, tag);
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < 16; i++) rd(i, tag);
    endtask

    initial begin
        #100000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        read_all("R1 reset entry");
        rd(16, "R1 reset status");
        check("R1 irq after reset", irq, 0);

        irq_en = 1'b1;
        frame(8'h11, "R5"); frame(8'h22, "R5"); frame(8'h7F, "R5");
        rd(0, "R5 discard e0"); rd(1, "R5 discard e1"); rd(16, "R5 no flag");

        step(1'b0, 8'hC5, 1'b0, 0, "R10");
        rd(0, "R10 no write"); rd(16, "R10 no flag");

        frame(8'hB5, "R2");
        rd(0, "R2 marker with CRC");
        rd(16, "R7 flag set");
        rd(16, "R7 cleared by read");
        for (int i = 1; i < 16; i++) frame(8'(i * 5), "R3");
        read_all("R3 fill order");

        frame(8'h55, "R4"); frame(8'h66, "R4");
        read_all("R4 after full");

        frame(8'hAA, "R6"); frame(8'h01, "R6"); frame(8'h02, "R6");
        frame(8'h81, "R6"); frame(8'h03, "R6");
        read_all("R6 resync");
        rd(16, "R6 flag");

        step(1'b1, 8'hF0, 1'b1, 16, "R8 read old value");
        rd(16, "R8 flag kept");
        rd(16, "R8 then cleared");

        irq_en = 1'b0;
        frame(8'h90, "R9");
        check("R9 masked irq", irq, 0);
        @(negedge clk); irq_en = 1'b1; #1;
        check("R9 enabled irq", irq, 1);
        rd(16, "R9 flag set while masked");

        rd(17, "R7 unused addr"); rd(31, "R7 unused addr");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule